// File: doc/BRIEF.md
# I2C Stuck Bus Recovery Controller

This block guards one I2C segment against a line that never comes back up. It samples SDA and SCL through two-flop synchronizers and counts prescaled time ticks while either line is low. If neither sample shows both lines high for a full timeout interval, the block takes the segment over. It first drops every pull-down that the normal bridging path asks for. It then toggles SCL as an open-drain master to clock out whatever slave is holding SDA, and finishes with a STOP condition.

In normal operation the two open-drain enables pass straight through from the bridging logic. The recovery burst stops early once SDA and SCL are both seen high at the end of a clock-high phase, and it never exceeds a fixed pulse cap. After a recovery the timeout re-arms from zero, so a bus that stays stuck gets one attempt per timeout interval, not a continuous loop. With a 125 MHz clock, `CLK_PER_TICK` = 125 gives a 1 µs tick. `STUCK_TICKS` = 37000 then gives a 37 ms timeout, and `HALF_TICKS` = 5 gives 5 µs clock phases.

Top module: `i2c_unstick`

## Requirements
- R1: After reset `recovering` is 0 and no recovery starts while both lines stay high.
- R2: If SDA or SCL is low without a break for `STUCK_TICKS` ticks (one tick every `CLK_PER_TICK` clocks), `recovering` rises between (STUCK_TICKS-1)*CLK_PER_TICK and STUCK_TICKS*CLK_PER_TICK+6 clocks after the line falls.
- R3: Any synchronized sample with both lines high clears the stuck timer. Low stretches shorter than the timeout, separated by short high gaps, never start a recovery.
- R4: In the cycle `recovering` rises, `sda_oe` and `scl_oe` are both 0, even if the bridge requests are 1. Bridge requests have no effect until `recovering` falls.
- R5: The recovery issues SCL pulses, each `HALF_TICKS` ticks low and then `HALF_TICKS` ticks released, and never more than `MAX_PULSES` of them.
- R6: If SDA and SCL are both sampled high at the end of a released phase, no further pulse is issued and the STOP follows at once. A slave that frees SDA on the Nth SCL rise gives N pulses (N ≤ MAX_PULSES).
- R7: The recovery ends with a STOP. `sda_oe` rises only while `scl_oe` has been high, and then falls while `scl_oe` has been 0. `recovering` stays high until the STOP is complete, and both enables are 0 when it falls.
- R8: If SCL is held low externally, the recovery still ends after `MAX_PULSES` pulses. The next recovery starts no sooner than a full new timeout.
- R9: While `recovering` is 0, `sda_oe` equals `bridge_sda_oe` and `scl_oe` equals `bridge_scl_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Sensed SDA level (asynchronous) |
| scl_in | input | 1 | Sensed SCL level (asynchronous) |
| bridge_sda_oe | input | 1 | Normal-path request to pull SDA low |
| bridge_scl_oe | input | 1 | Normal-path request to pull SCL low |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| recovering | output | 1 | High from timeout detection to STOP completion |

## Verification
A timer that fails to clear shows up as a spurious `recovering` rise after a series of short low stretches, within about one timeout interval. A sequencer stuck in the wrong phase or with a wrong pulse count shows up in the number of `scl_oe` falls during the burst. A wrong pulse count shows up within one pulse period of the expected end. A misordered STOP shows up as an `sda_oe` edge while SCL is released, on the very edge where it happens. A leaking bridge request is visible at `sda_oe` or `scl_oe` in the first cycle of recovery.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RELEASE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C,
    ST_STOP_D
  } rec_state_t;

  // True when a counter sits on the last value of a span of `span` steps.
  function automatic logic at_last(input logic [31:0] cnt, input logic [31:0] span);
    return (cnt + 32'd1) == span;
  endfunction

  // Bus is free when both lines read high.
  function automatic logic bus_free(input logic sda, input logic scl);
    return sda & scl;
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        stab_q <= 1'b1;
      end else begin
        meta_q <= din[g];
        stab_q <= meta_q;
      end
    end
    assign dout[g] = stab_q;
  end
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  if (DIV <= 1) begin : g_every
    assign tick = 1'b1;
  end else begin : g_div
    localparam int DW = $clog2(DIV);
    logic [DW-1:0] div_q;
    logic          wrap;
    assign wrap = unstick_pkg::at_last(32'(div_q), 32'(DIV));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (wrap) div_q <= '0;
      else           div_q <= div_q + 1'b1;
    end
    assign tick = wrap;

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2
  end
endmodule

// File: rtl/stuck_timer.sv
module stuck_timer #(
  parameter int STUCK_TICKS = 37000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic sda_s,
  input  logic scl_s,
  output logic timeout
);
  import unstick_pkg::*;
  localparam int CW = $clog2(STUCK_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          line_low;
  logic          clear_evt;

  assign line_low  = !bus_free(sda_s, scl_s);
  assign clear_evt = !arm || !line_low;
  assign timeout   = arm && line_low && tick && at_last(32'(cnt_q), 32'(STUCK_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clear_evt) cnt_q <= '0;
    else if (timeout)   cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_s && scl_s) |=> (cnt_q == '0)); // R3
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < 32'(STUCK_TICKS)); // R2
endmodule

// File: rtl/recovery_fsm.sv
module recovery_fsm #(
  parameter int HALF_TICKS = 5,
  parameter int MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic timeout,
  input  logic sda_s,
  input  logic scl_s,
  output logic sda_pd,
  output logic scl_pd,
  output logic active,
  output logic idle
);
  import unstick_pkg::*;
  localparam int PW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam int NW = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1;

  rec_state_t    state_q, state_d;
  logic [PW-1:0] ph_q;
  logic [NW-1:0] pulse_q;
  logic          ph_done;
  logic          pulse_done;
  logic          early_exit;
  logic          cap_hit;

  assign ph_done    = tick && at_last(32'(ph_q), 32'(HALF_TICKS));
  assign pulse_done = (state_q == ST_CLK_HI) && ph_done;
  assign early_exit = pulse_done && bus_free(sda_s, scl_s);
  assign cap_hit    = pulse_done && at_last(32'(pulse_q), 32'(MAX_PULSES));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (timeout) state_d = ST_RELEASE;
      ST_RELEASE: if (ph_done) state_d = ST_CLK_LO;
      ST_CLK_LO:  if (ph_done) state_d = ST_CLK_HI;
      ST_CLK_HI:  if (pulse_done) state_d = (early_exit || cap_hit) ? ST_STOP_A : ST_CLK_LO;
      ST_STOP_A:  if (ph_done) state_d = ST_STOP_B;
      ST_STOP_B:  if (ph_done) state_d = ST_STOP_C;
      ST_STOP_C:  if (ph_done) state_d = ST_STOP_D;
      ST_STOP_D:  if (ph_done) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE || state_d != state_q) ph_q <= '0;
      else if (tick)                                ph_q <= ph_q + 1'b1;
      if (state_q == ST_IDLE)                           pulse_q <= '0;
      else if (pulse_done && !early_exit && !cap_hit)   pulse_q <= pulse_q + 1'b1;
    end
  end

  always_comb begin
    scl_pd = 1'b0;
    sda_pd = 1'b0;
    unique case (state_q)
      ST_CLK_LO: scl_pd = 1'b1;
      ST_STOP_A: scl_pd = 1'b1;
      ST_STOP_B: begin scl_pd = 1'b1; sda_pd = 1'b1; end
      ST_STOP_C: sda_pd = 1'b1;
      default: ;
    endcase
  end

  assign active = (state_q != ST_IDLE);
  assign idle   = (state_q == ST_IDLE);

  AST_DETECT_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> idle); // R2
  AST_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CLK_HI) && ph_done && sda_s && scl_s) |=> (state_q == ST_STOP_A)); // R6
  AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd) |-> (scl_pd && $past(scl_pd))); // R7
  AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pd) |-> (!scl_pd && !$past(scl_pd))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pulse_q) < 32'(MAX_PULSES)); // R5
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick #(
  parameter int CLK_PER_TICK = 125,
  parameter int STUCK_TICKS  = 37000,
  parameter int HALF_TICKS   = 5,
  parameter int MAX_PULSES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_in,
  input  logic scl_in,
  input  logic bridge_sda_oe,
  input  logic bridge_scl_oe,
  output logic sda_oe,
  output logic scl_oe,
  output logic recovering
);
  logic [1:0] raw_lines;
  logic [1:0] sync_lines;
  logic       sda_s, scl_s;
  logic       tick;
  logic       timeout;
  logic       rec_sda_pd, rec_scl_pd;
  logic       rec_active, rec_idle;

  assign raw_lines = {scl_in, sda_in};
  assign sda_s     = sync_lines[0];
  assign scl_s     = sync_lines[1];

  line_sync #(.WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_lines), .dout(sync_lines)
  );

  tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  stuck_timer #(.STUCK_TICKS(STUCK_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(rec_idle),
    .sda_s(sda_s), .scl_s(scl_s), .timeout(timeout)
  );

  recovery_fsm #(.HALF_TICKS(HALF_TICKS), .MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .timeout(timeout),
    .sda_s(sda_s), .scl_s(scl_s), .sda_pd(rec_sda_pd), .scl_pd(rec_scl_pd),
    .active(rec_active), .idle(rec_idle)
  );

  assign sda_oe     = rec_active ? rec_sda_pd : bridge_sda_oe;
  assign scl_oe     = rec_active ? rec_scl_pd : bridge_scl_oe;
  assign recovering = rec_active;

  AST_RELEASE_ON_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovering) |-> (!sda_oe && !scl_oe)); // R4
  AST_CLEAN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recovering) |-> (!$past(sda_oe) && !$past(scl_oe))); // R7
  AST_ENTRY_FROM_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovering) |-> $past(timeout)); // R2
endmodule

// File: tb/i2c_unstick_tb.sv
`timescale 1ns/1ps
module i2c_unstick_tb;
  localparam int C = 4;
  localparam int L = 40;
  localparam int H = 3;
  localparam int P = 16;
  localparam int NV = 4;
  // release-after-N-rises (0 = never), expected scl_oe falls (pulses + STOP)
  localparam int VEC_REL [NV] = '{1, 3, 16, 0};
  localparam int VEC_EXP [NV] = '{2, 4, 17, 17};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bridge_sda_oe = 1'b0, bridge_scl_oe = 1'b0;
  logic ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  int   dev_rel = 0, dev_base = 0;
  int   scl_rises = 0;
  int   scl_falls = 0, start_bad = 0, stop_good = 0;
  int   n_chk = 0, n_fail = 0;
  logic sda_oe, scl_oe, recovering;
  logic sda_hold, sda_in, scl_in;
  logic prev_rec = 1'b0, prev_sda_oe = 1'b0, prev_scl_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_hold = ext_sda_low && !(dev_rel != 0 && (scl_rises - dev_base) >= dev_rel);
  assign sda_in   = !(sda_oe || sda_hold);
  assign scl_in   = !(scl_oe || ext_scl_low);

  i2c_unstick #(.CLK_PER_TICK(C), .STUCK_TICKS(L), .HALF_TICKS(H), .MAX_PULSES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
    .bridge_sda_oe(bridge_sda_oe), .bridge_scl_oe(bridge_scl_oe),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .recovering(recovering)
  );

  always @(posedge scl_in) scl_rises++;

  always @(negedge clk) begin
    if (prev_rec && recovering) begin
      if (prev_scl_oe && !scl_oe) scl_falls++;
      if (!prev_sda_oe && sda_oe && !(scl_oe && prev_scl_oe)) start_bad++;
      if (prev_sda_oe && !sda_oe && !scl_oe && !prev_scl_oe) stop_good++;
    end
    prev_rec    = recovering;
    prev_sda_oe = sda_oe;
    prev_scl_oe = scl_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rec(input logic lvl, input int max_cyc, output int cyc);
    cyc = 0;
    while (recovering !== lvl && cyc < max_cyc) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int cyc, f0, s0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(recovering == 1'b0, "R1 reset recovering", recovering, 0);
    chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R1 reset enables", {sda_oe, scl_oe}, 0);
    // R9: pass-through while idle
    bridge_sda_oe = 1'b1;
    #1 chk(sda_oe == 1'b1 && scl_oe == 1'b0, "R9 pass sda", {sda_oe, scl_oe}, 2);
    bridge_sda_oe = 1'b0; bridge_scl_oe = 1'b1;
    #1 chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R9 pass scl", {sda_oe, scl_oe}, 1);
    bridge_scl_oe = 1'b0;
    @(negedge clk);
    repeat ((L + 4) * C) @(negedge clk);
    chk(recovering == 1'b0, "R1 quiet bus", recovering, 0);

    // Vector table: slave holds SDA, frees it after N SCL rises
    for (int i = 0; i < NV; i++) begin
      f0 = scl_falls; s0 = stop_good; b0 = start_bad;
      dev_base = scl_rises; dev_rel = VEC_REL[i];
      ext_sda_low = 1'b1;
      wait_rec(1'b1, 4 * L * C, cyc);
      chk(cyc >= (L - 1) * C && cyc <= L * C + 6, "R2 detect delay", cyc, L * C);
      chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R4 released on detect", {sda_oe, scl_oe}, 0);
      wait_rec(1'b0, 4000, cyc);
      chk(scl_falls - f0 == VEC_EXP[i], "R5 R6 pulse count", scl_falls - f0, VEC_EXP[i]);
      chk(stop_good - s0 == 1, "R7 stop generated", stop_good - s0, 1);
      chk(start_bad - b0 == 0, "R7 no start", start_bad - b0, 0);
      chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R7 clean exit", {sda_oe, scl_oe}, 0);
      ext_sda_low = 1'b0; dev_rel = 0;
      repeat (10) @(negedge clk);
    end

    // R3: short low stretches separated by brief high gaps
    for (int k = 0; k < 3; k++) begin
      ext_sda_low = 1'b1;
      repeat ((L - 2) * C) @(negedge clk);
      ext_sda_low = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (2 * C) @(negedge clk);
    chk(recovering == 1'b0, "R3 timer cleared by high sample", recovering, 0);

    // R4: own bridge pull-down holds SDA; masked during recovery
    bridge_sda_oe = 1'b1;
    f0 = scl_falls;
    wait_rec(1'b1, 4 * L * C, cyc);
    chk(recovering == 1'b1, "R4 bridge stuck detected", recovering, 1);
    chk(sda_oe == 1'b0, "R4 bridge request masked", sda_oe, 0);
    wait_rec(1'b0, 4000, cyc);
    chk(scl_falls - f0 == 2, "R4 R6 early exit after one pulse", scl_falls - f0, 2);
    chk(sda_oe == 1'b1, "R9 bridge restored after recovery", sda_oe, 1);
    bridge_sda_oe = 1'b0;
    repeat (10) @(negedge clk);

    // R8: SCL held low externally
    ext_scl_low = 1'b1;
    f0 = scl_falls;
    wait_rec(1'b1, 4 * L * C, cyc);
    chk(cyc >= (L - 1) * C && cyc <= L * C + 6, "R2 scl detect delay", cyc, L * C);
    wait_rec(1'b0, 4000, cyc);
    chk(scl_falls - f0 == P + 1, "R8 R5 capped pulses", scl_falls - f0, P + 1);
    wait_rec(1'b1, 4 * L * C, cyc);
    chk(recovering == 1'b1, "R8 re-armed attempt", recovering, 1);
    chk(cyc >= (L - 1) * C, "R8 full timeout before retry", cyc, L * C);
    ext_scl_low = 1'b0;
    wait_rec(1'b0, 4000, cyc);
    chk(recovering == 1'b0, "R8 retry completes", recovering, 0);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule